// File: doc/BRIEF.md
# Indexed Load/Store Memory Sequencer

This block carries out the memory half of a small processor's load and store instructions. When the core hands it an instruction word together with the current program counter, the contents of the index register and the register value to be stored, the block forms an effective address and runs the accesses on one external memory port. The port has an address bus, a write-data bus, a read-data bus, a write strobe and a fetch indicator. A load returns the word it read to the register file, and a store writes the register value to memory. A one-cycle done pulse closes each operation.

There are two displacement encodings. The long form reads a full-width displacement from the instruction word that follows in program memory, so it uses one extra bus cycle and moves the program counter past that word. The quick form takes a signed 4-bit displacement from the instruction itself. The register file sits outside the block: the block reports which registers to read and receives their values in the same cycle as the start request. Memory is assumed to answer a read within the cycle in which the address is presented.

Top module: `lsu_memseq`

## Requirements
- R1: Out of reset, `busy`, `done`, `mem_we`, `mem_fetch` and `rf_we` are all low.
- R2: The block splits the instruction into four fields. Bits 15:12 are the opcode: 1100 is a long load, 1101 a long store, 1110 a quick load and 1111 a quick store. Bits 11:8 select the data register and appear on `rf_ra_dat`. Bits 7:4 select the index register and appear on `rf_ra_idx`. Bits 3:0 hold the quick displacement. A start carrying any other opcode is ignored: `busy` stays low and there is no fetch, write or done.
- R3: A long operation begins with one bus cycle that reads address `pc_in`, with `mem_fetch` high and `mem_we` low.
- R4: For the long form, the effective address is the index value plus the word read in that fetch cycle, modulo 2^16. `pc_next` is then `pc_in`+1.
- R5: For the quick form, the effective address is the index value plus bits 3:0 sign-extended to 16 bits, modulo 2^16. This bus cycle comes in the first cycle after acceptance, and `pc_next` equals `pc_in`.
- R6: During the data cycle `mem_fetch` is low. A load holds `mem_we` low. A store drives `mem_we` high and puts on `mem_wdata` the `st_val` captured at acceptance.
- R7: `done` is high for exactly one cycle. It comes 2 cycles after the accepting edge for a quick operation and 3 cycles after it for a long one, and `busy` is low from that point on.
- R8: For a load, `rf_we` is high in the `done` cycle, with `rf_waddr` set to the data-register field and `rf_wdata` set to the word read at the effective address. For a store, `rf_we` stays low.
- R9: A start raised while `busy` is high is ignored. The running operation finishes with its own fields, and no second operation follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the presented instruction |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | Address of the word following the instruction |
| idx_val | input | 16 | Index register contents |
| st_val | input | 16 | Data register contents (store source) |
| rf_ra_idx | output | 4 | Register file read select for the index |
| rf_ra_dat | output | 4 | Register file read select for the data register |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_we | output | 1 | Memory write strobe |
| mem_fetch | output | 1 | High during instruction-stream reads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_we | output | 1 | Register write-back enable |
| rf_waddr | output | 4 | Register write-back select |
| rf_wdata | output | 16 | Register write-back data |
| pc_next | output | 16 | Program counter after the operation |

## Verification
The bench runs every quick displacement from -8 to +7 against index values chosen to wrap across zero and across the top of the address space. A design that zero-extends the field, or that carries past 16 bits, would put the wrong address on the bus. The long form is run with extension words that wrap and with large negative values, which catches a design that takes the displacement from the instruction, skips the fetch strobe, or leaves the program counter unadvanced. Each operation is timed to the exact cycle, and on half of them a second start is held during the busy phase. A design that counted cycles wrongly, stretched the done pulse, or accepted a request while busy would fail on timing or on the register it writes back. All twelve non-memory opcodes are also sent, to confirm they leave the bus untouched.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int IW  = 16;  // instruction word width
  localparam int FW  = 4;   // register select field width
  localparam int OPW = 4;   // opcode width

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EXT  = 2'd1,
    S_ACC  = 2'd2
  } lsu_state_t;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [FW-1:0]  dat;
    logic [FW-1:0]  idx;
    logic [FW-1:0]  qd;
  } lsu_instr_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [OPW-1:0] op,
  output logic           is_mem,
  output logic           is_long,
  output logic           is_store
);
  // memory ops occupy the top quarter of the opcode space
  always_comb begin
    is_mem   = (op[OPW-1:OPW-2] == 2'b11);
    is_long  = is_mem & ~op[1];
    is_store = is_mem & op[0];
  end
endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int QW = 4
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] disp_long,
  input  logic [QW-1:0] disp_quick,
  input  logic          use_long,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] disp;
  logic [AW-1:0] qext;

  generate
    if (AW > QW) begin : g_sext
      assign qext = {{(AW-QW){disp_quick[QW-1]}}, disp_quick};
    end else begin : g_trunc
      assign qext = disp_quick[AW-1:0];
    end
  endgenerate

  always_comb begin
    disp = use_long ? disp_long[AW-1:0] : qext;
    ea   = base[AW-1:0] + disp;
  end
endmodule

// File: rtl/lsu_memseq.sv
module lsu_memseq
  import lsu_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int QW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IW-1:0]   instr,
  input  logic [AW-1:0]   pc_in,
  input  logic [DW-1:0]   idx_val,
  input  logic [DW-1:0]   st_val,
  output logic [FW-1:0]   rf_ra_idx,
  output logic [FW-1:0]   rf_ra_dat,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_we,
  output logic            mem_fetch,
  output logic            busy,
  output logic            done,
  output logic            rf_we,
  output logic [FW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic [AW-1:0]   pc_next
);
  lsu_instr_t fld;
  lsu_state_t state;
  logic       is_mem, is_long, is_store;
  logic       store_q;
  logic [FW-1:0] dat_q;
  logic [DW-1:0] idx_q;
  logic [DW-1:0] sdat_q;
  logic [AW-1:0] ea;
  logic [DW-1:0] ea_base;
  logic          ea_long;

  assign fld       = lsu_instr_t'(instr);
  assign rf_ra_idx = fld.idx;
  assign rf_ra_dat = fld.dat;

  lsu_decode u_dec (
    .op       (fld.op),
    .is_mem   (is_mem),
    .is_long  (is_long),
    .is_store (is_store)
  );

  // idle: quick address from live inputs; otherwise captured index + fetched word
  assign ea_base = (state == S_IDLE) ? idx_val : idx_q;
  assign ea_long = (state != S_IDLE);

  lsu_ea_gen #(.AW(AW), .DW(DW), .QW(QW)) u_ea (
    .base       (ea_base),
    .disp_long  (mem_rdata),
    .disp_quick (fld.qd[QW-1:0]),
    .use_long   (ea_long),
    .ea         (ea)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      store_q   <= 1'b0;
      dat_q     <= '0;
      idx_q     <= '0;
      sdat_q    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_fetch <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      pc_next   <= '0;
    end else begin
      done  <= 1'b0;
      rf_we <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start && is_mem) begin
            busy    <= 1'b1;
            store_q <= is_store;
            dat_q   <= fld.dat;
            idx_q   <= idx_val;
            sdat_q  <= st_val;
            if (is_long) begin
              mem_addr  <= pc_in;
              mem_fetch <= 1'b1;
              mem_we    <= 1'b0;
              pc_next   <= pc_in + 1'b1;
              state     <= S_EXT;
            end else begin
              mem_addr  <= ea;
              mem_fetch <= 1'b0;
              mem_we    <= is_store;
              mem_wdata <= is_store ? st_val : '0;
              pc_next   <= pc_in;
              state     <= S_ACC;
            end
          end
        end
        S_EXT: begin
          mem_addr  <= ea;
          mem_fetch <= 1'b0;
          mem_we    <= store_q;
          mem_wdata <= store_q ? sdat_q : '0;
          state     <= S_ACC;
        end
        S_ACC: begin
          mem_we   <= 1'b0;
          busy     <= 1'b0;
          done     <= 1'b1;
          rf_we    <= ~store_q;
          rf_waddr <= dat_q;
          rf_wdata <= mem_rdata;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_memseq_chk.sv
module lsu_memseq_chk (
  input logic clk,
  input logic rst,
  input logic mem_we,
  input logic mem_fetch,
  input logic busy,
  input logic done,
  input logic rf_we
);
  // R3: instruction-stream reads never write
  p_fetch_read_r3: assert property (@(posedge clk) disable iff (rst)
    mem_fetch |-> !mem_we);

  // R6: the cycle after a fetch is the data access, without the strobe
  p_fetch_then_data_r6: assert property (@(posedge clk) disable iff (rst)
    mem_fetch |=> (busy && !mem_fetch));

  // R7: completion is a single-cycle pulse that ends the busy phase
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: write-back only accompanies completion
  p_wb_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> done);

  // R2: no bus activity outside an operation
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_fetch));
endmodule

bind lsu_memseq lsu_memseq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_we    (mem_we),
  .mem_fetch (mem_fetch),
  .busy      (busy),
  .done      (done),
  .rf_we     (rf_we)
);

// File: tb/lsu_memseq_test.sv
module lsu_memseq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_in = '0;
  logic [15:0] idx_val = '0;
  logic [15:0] st_val = '0;
  logic [3:0]  rf_ra_idx, rf_ra_dat;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, mem_fetch, busy, done, rf_we;
  logic [3:0]  rf_waddr;
  logic [15:0] rf_wdata, pc_next;
  logic [15:0] ext_word = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  // memory model: extension word on fetch, arithmetic content otherwise
  assign mem_rdata = mem_fetch ? ext_word : memf(mem_addr);

  lsu_memseq uut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .pc_in(pc_in),
    .idx_val(idx_val), .st_val(st_val), .rf_ra_idx(rf_ra_idx),
    .rf_ra_dat(rf_ra_dat), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_fetch(mem_fetch),
    .busy(busy), .done(done), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .pc_next(pc_next)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [3:0] rd,
                        input logic [15:0] idx, input logic [3:0] q,
                        input logic [15:0] ext, input logic [15:0] pc,
                        input logic [15:0] sv, input bit hold);
    logic        lng, st;
    logic [15:0] ea;
    lng = ~op[1];
    st  = op[0];
    ea  = lng ? idx + ext : idx + {{12{q[3]}}, q};
    @(negedge clk);
    instr = {op, rd, 4'h5, q};
    pc_in = pc; idx_val = idx; st_val = sv; ext_word = ext;
    start = 1'b1;
    #1;
    chk(rf_ra_dat == rd, "R2 data select", rf_ra_dat, rd);
    chk(rf_ra_idx == 4'h5, "R2 index select", rf_ra_idx, 4'h5);
    @(negedge clk);
    if (hold) begin
      // R9: competing request while busy
      instr = {4'hE, ~rd, 4'h5, q}; idx_val = ~idx; st_val = ~sv;
    end else begin
      start = 1'b0;
    end
    chk(busy == 1'b1, "R7 busy after accept", busy, 1);
    if (lng) begin
      chk(mem_addr == pc, "R3 fetch address", mem_addr, pc);
      chk(mem_fetch == 1'b1 && mem_we == 1'b0, "R3 fetch strobes",
          {mem_fetch, mem_we}, 2'b10);
      chk(done == 1'b0, "R7 no early done", done, 0);
      @(negedge clk);
      start = 1'b0;
    end
    start = 1'b0;
    chk(mem_addr == ea, lng ? "R4 long address" : "R5 quick address", mem_addr, ea);
    chk(mem_fetch == 1'b0 && mem_we == st, "R6 data strobes",
        {mem_fetch, mem_we}, {1'b0, st});
    if (st) chk(mem_wdata == sv, "R6 store data", mem_wdata, sv);
    chk(done == 1'b0, "R7 no early done", done, 0);
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R7 done timing", {done, busy}, 2'b10);
    chk(rf_we == ~st, "R8 write-back enable", rf_we, ~st);
    if (!st) begin
      chk(rf_waddr == rd, "R8 R9 write-back select", rf_waddr, rd);
      chk(rf_wdata == memf(ea), "R8 write-back data", rf_wdata, memf(ea));
    end
    chk(pc_next == (lng ? pc + 16'd1 : pc), lng ? "R4 pc" : "R5 pc", pc_next,
        lng ? pc + 16'd1 : pc);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0 && mem_we == 1'b0, "R7 R9 pulse ends",
        {done, busy, mem_we}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, mem_we, mem_fetch, rf_we} == 5'b0, "R1 reset state",
        {busy, done, mem_we, mem_fetch, rf_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, mem_we, mem_fetch, rf_we} == 5'b0, "R1 after release",
        {busy, done, mem_we, mem_fetch, rf_we}, 0);

    // R2: non-memory opcodes are ignored
    for (int op = 0; op < 12; op++) begin
      @(negedge clk);
      instr = {op[3:0], 4'h3, 4'h5, 4'h7};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!busy && !mem_we && !mem_fetch, "R2 ignored opcode",
          {busy, mem_we, mem_fetch}, 0);
      @(negedge clk);
      chk(!done && !rf_we && !busy, "R2 ignored no done", {done, rf_we, busy}, 0);
    end

    // R5: every quick displacement against wrapping index values
    for (int i = 0; i < 4; i++) begin
      for (int q = 0; q < 16; q++) begin
        for (int s = 0; s < 2; s++) begin
          logic [15:0] iv;
          iv = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFC : (i == 2) ? 16'h0004 : 16'h8001;
          run_op({3'b111, s[0]}, q[3:0] ^ 4'h9, iv, q[3:0], 16'h0000,
                 16'h1000 + 16'(q), 16'hC3A5 ^ 16'(q * 7), (q % 2) == 1);
        end
      end
    end

    // R4: long displacements including wrap and negative values
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 2; s++) begin
        logic [15:0] xv;
        logic [15:0] iv;
        xv = (e == 0) ? 16'h0000 : (e == 1) ? 16'hFFFF : (e == 2) ? 16'h8000 :
             (e == 3) ? 16'h7FFF : 16'(e * 16'h1357);
        iv = 16'(e * 16'h2222) + 16'h0F0F;
        run_op({3'b110, s[0]}, 4'(e), iv, 4'hF, xv, 16'hFFFF - 16'(e * 3),
               16'(e * 16'h0101), (e % 2) == 0);
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule